// File: doc/BRIEF.md
# Response Integrity-Check Appender and Fragmenter

This block sits between a response buffer and a byte-oriented transport. When it is started with a response length, it reads the response bytes from the buffer, one per clock, and folds each into a CRC-32C register. After that pass the message is ready. Its length is the response length plus four, and the four CRC bytes follow the payload, least significant byte first. A caller then asks for fragments, giving a maximum size with each request. The block streams out that many bytes, or fewer if less of the message is left. Each byte carries flags that mark the end of its fragment, the end of the message, and whether the fragment began at offset zero. A request made when nothing is left gets a one-cycle empty indication instead of bytes. Once the last byte of the message has been sent, the message is gone and the block is idle.

A separate receive path builds a request buffer from incoming fragments. Each fragment is announced with its length. If it would push the stored total past the limit, it is refused: an error pulse is raised and its bytes are drained without being written. Otherwise its bytes are written at consecutive buffer addresses, starting from the current stored length. A clear input drops the stored length to zero.

Back-pressure rules: a fragment request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while the CRC pass runs and while a fragment is being sent. An output byte moves when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and its flags hold steady. On receive, a header is taken when `rx_hdr_valid` and `rx_hdr_ready` are high, and a data byte when `rx_valid` and `rx_ready` are high.

Top module: `mic_fragmenter`

## Requirements
- R1: The appended check is a reflected CRC-32C (reversed polynomial 0x82F63B78). It starts from 0xFFFFFFFF, takes in buffer bytes 0 to len-1 in address order, and is not inverted at the end.
- R2: The message is bytes 0 to len-1 of the buffer followed by the four CRC bytes, lowest byte first, for a total of len+4 bytes.
- R3: An accepted request with maximum m streams exactly min(m, bytes remaining) bytes. If that count is zero, no byte is sent and `out_nil` pulses for one cycle, in the cycle after acceptance.
- R4: `out_som` is high on every byte of the fragment that starts at message offset 0, and low on every other byte. `out_eof` is high only on the last byte of each fragment.
- R5: `out_eom` is high only on the final byte of the message, together with `out_eof`. After that byte the message is cleared, so any later request returns `out_nil`.
- R6: After an accepted start with len > 0, `tx_busy` is high for exactly len cycles and `req_ready` stays low throughout. A `tx_start` during that pass is ignored.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_eof` and `out_eom` stay unchanged into the next cycle.
- R8: Let the stored length plus the header length be the new total. If it exceeds RX_MAX, `rx_err` pulses in the cycle after the header is taken, and the fragment's bytes are consumed with no write. Otherwise the bytes are written at consecutive addresses starting at the stored length, and `rx_count` grows by the header length.
- R9: `rx_reset` sets `rx_count` to zero in the next cycle and drops any fragment that is partly received, so `rx_hdr_ready` is high again.
- R10: After reset, `req_ready` and `rx_hdr_ready` are high, and `out_valid`, `tx_busy` and `rx_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Starts a new response; taken when idle or between fragments |
| tx_len | input | TLW | Response length in bytes, header included |
| tx_busy | output | 1 | High while the CRC pass runs |
| buf_addr | output | TLW | Response buffer read address |
| buf_data | input | 8 | Response buffer read data for `buf_addr` (same cycle) |
| req_valid | input | 1 | Fragment request valid |
| req_ready | output | 1 | Fragment request ready |
| req_max | input | FRAG_W | Largest fragment size wanted |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte ready |
| out_data | output | 8 | Output byte |
| out_som | output | 1 | Byte belongs to the fragment starting at offset 0 |
| out_eof | output | 1 | Last byte of the fragment |
| out_eom | output | 1 | Last byte of the message |
| out_nil | output | 1 | One-cycle pulse: request produced no bytes |
| rx_hdr_valid | input | 1 | Incoming fragment header valid |
| rx_hdr_ready | output | 1 | Header can be taken (no fragment in progress) |
| rx_hdr_len | input | RLW | Byte count of the incoming fragment |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Incoming byte ready |
| rx_data | input | 8 | Incoming byte |
| rx_reset | input | 1 | Clears the stored request length |
| rx_err | output | 1 | One-cycle pulse: fragment refused for overflow |
| wr_en | output | 1 | Request buffer write strobe |
| wr_addr | output | RLW | Request buffer write address |
| wr_data | output | 8 | Request buffer write data |
| rx_count | output | RLW | Stored request length |

## Verification
The case hardest to reach from the ports is a second start that arrives while the CRC pass is still running. The stimulus drives `tx_start` with a different length in the third busy cycle. It then checks that the whole message that follows still has the first length and the first CRC. The receive limit is another hard edge. The bench uses a small RX_MAX so that it can fill the buffer to exactly the limit and then offer a one-byte fragment that must be refused. A sweep over response lengths and fragment sizes, some runs with a stalling consumer, covers every split of a message, the CRC bytes included, against values the bench computes.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'h82F6_3B78;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_CRC,
    TX_HOLD,
    TX_SEND
  } tx_state_e;

  // one reflected byte step of the check register
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/mfr_crc32c.sv
module mfr_crc32c (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import mfr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (en)   crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/mfr_tx.sv
module mfr_tx #(
  parameter int LW = 13,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [LW-1:0] tx_len,
  output logic          tx_busy,
  output logic [LW-1:0] buf_addr,
  input  logic [7:0]    buf_data,
  output logic          crc_init,
  output logic          crc_en,
  output logic [7:0]    crc_byte,
  input  logic [31:0]   crc_val,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_max,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_som,
  output logic          out_eof,
  output logic          out_eom,
  output logic          out_nil
);
  import mfr_pkg::*;

  localparam int CW = (LW > FW) ? LW : FW;

  tx_state_e     state;
  logic [LW-1:0] plen;
  logic [LW-1:0] idx;
  logic [CW-1:0] left;
  logic          head;
  logic          nil_q;

  logic          open_st;
  logic          start_acc;
  logic          req_acc;
  logic [LW-1:0] total;
  logic [CW-1:0] rem_w;
  logic [CW-1:0] max_w;
  logic [CW-1:0] take;
  logic          last_byte;
  logic [1:0]    off;
  logic [7:0]    crc_sel;

  assign open_st   = (state == TX_IDLE) || (state == TX_HOLD);
  assign start_acc = open_st && tx_start;
  assign req_ready = open_st && !tx_start;
  assign req_acc   = req_valid && req_ready;

  assign total     = plen + LW'(4);
  assign rem_w     = (state == TX_HOLD) ? CW'(total - idx) : '0;
  assign max_w     = CW'(req_max);
  assign take      = (max_w < rem_w) ? max_w : rem_w;
  assign last_byte = (idx == total - LW'(1));

  // position within the appended check, low byte first
  assign off = idx[1:0] - plen[1:0];
  always_comb begin
    case (off)
      2'd0:    crc_sel = crc_val[7:0];
      2'd1:    crc_sel = crc_val[15:8];
      2'd2:    crc_sel = crc_val[23:16];
      default: crc_sel = crc_val[31:24];
    endcase
  end

  assign buf_addr  = idx;
  assign crc_init  = start_acc;
  assign crc_en    = (state == TX_CRC);
  assign crc_byte  = buf_data;
  assign tx_busy   = (state == TX_CRC);

  assign out_valid = (state == TX_SEND);
  assign out_data  = (idx < plen) ? buf_data : crc_sel;
  assign out_som   = out_valid && head;
  assign out_eof   = out_valid && (left == CW'(1));
  assign out_eom   = out_valid && last_byte;
  assign out_nil   = nil_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      plen  <= '0;
      idx   <= '0;
      left  <= '0;
      head  <= 1'b0;
      nil_q <= 1'b0;
    end else begin
      nil_q <= 1'b0;
      case (state)
        TX_IDLE, TX_HOLD: begin
          if (start_acc) begin
            plen  <= tx_len;
            idx   <= '0;
            state <= (tx_len == '0) ? TX_HOLD : TX_CRC;
          end else if (req_acc) begin
            if (take == '0) begin
              nil_q <= 1'b1;
            end else begin
              left  <= take;
              head  <= (idx == '0);
              state <= TX_SEND;
            end
          end
        end
        TX_CRC: begin
          if (idx == plen - LW'(1)) begin
            idx   <= '0;
            state <= TX_HOLD;
          end else begin
            idx <= idx + LW'(1);
          end
        end
        TX_SEND: begin
          if (out_ready) begin
            left <= left - CW'(1);
            if (left == CW'(1) && last_byte) begin
              idx   <= '0;
              plen  <= '0;
              state <= TX_IDLE;
            end else begin
              idx <= idx + LW'(1);
              if (left == CW'(1)) state <= TX_HOLD;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mfr_rx.sv
module mfr_rx #(
  parameter int RX_MAX = 4224,
  parameter int RLW    = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_hdr_valid,
  output logic           rx_hdr_ready,
  input  logic [RLW-1:0] rx_hdr_len,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [7:0]     rx_data,
  input  logic           rx_reset,
  output logic           rx_err,
  output logic           wr_en,
  output logic [RLW-1:0] wr_addr,
  output logic [7:0]     wr_data,
  output logic [RLW-1:0] rx_count
);

  logic [RLW-1:0] count;
  logic [RLW-1:0] left;
  logic           drop;
  logic           err_q;
  logic           hdr_acc;
  logic           byte_acc;
  logic [RLW:0]   sum;
  logic           over;

  assign rx_hdr_ready = (left == '0);
  assign rx_ready     = (left != '0);
  assign hdr_acc      = rx_hdr_valid && rx_hdr_ready && !rx_reset;
  assign byte_acc     = rx_valid && rx_ready && !rx_reset;
  assign sum          = {1'b0, count} + {1'b0, rx_hdr_len};
  assign over         = (sum > (RLW+1)'(RX_MAX));

  assign wr_en    = byte_acc && !drop;
  assign wr_addr  = count;
  assign wr_data  = rx_data;
  assign rx_count = count;
  assign rx_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      left  <= '0;
      drop  <= 1'b0;
      err_q <= 1'b0;
    end else if (rx_reset) begin
      count <= '0;
      left  <= '0;
      drop  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= hdr_acc && over;
      if (hdr_acc) begin
        left <= rx_hdr_len;
        drop <= over;
      end else if (byte_acc) begin
        left <= left - RLW'(1);
        if (!drop) count <= count + RLW'(1);
      end
    end
  end

endmodule

// File: rtl/mic_fragmenter.sv
module mic_fragmenter #(
  parameter  int TX_MAX_LEN = 4220,
  parameter  int RX_MAX     = 4224,
  parameter  int FRAG_W     = 8,
  localparam int TLW        = $clog2(TX_MAX_LEN + 5),
  localparam int RLW        = $clog2(RX_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [TLW-1:0]    tx_len,
  output logic              tx_busy,
  output logic [TLW-1:0]    buf_addr,
  input  logic [7:0]        buf_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FRAG_W-1:0] req_max,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_som,
  output logic              out_eof,
  output logic              out_eom,
  output logic              out_nil,
  input  logic              rx_hdr_valid,
  output logic              rx_hdr_ready,
  input  logic [RLW-1:0]    rx_hdr_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_reset,
  output logic              rx_err,
  output logic              wr_en,
  output logic [RLW-1:0]    wr_addr,
  output logic [7:0]        wr_data,
  output logic [RLW-1:0]    rx_count
);

  logic        crc_init;
  logic        crc_en;
  logic [7:0]  crc_byte;
  logic [31:0] crc_val;

  mfr_crc32c u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .en    (crc_en),
    .din   (crc_byte),
    .crc   (crc_val)
  );

  mfr_tx #(.LW(TLW), .FW(FRAG_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_len    (tx_len),
    .tx_busy   (tx_busy),
    .buf_addr  (buf_addr),
    .buf_data  (buf_data),
    .crc_init  (crc_init),
    .crc_en    (crc_en),
    .crc_byte  (crc_byte),
    .crc_val   (crc_val),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_max   (req_max),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_som   (out_som),
    .out_eof   (out_eof),
    .out_eom   (out_eom),
    .out_nil   (out_nil)
  );

  mfr_rx #(.RX_MAX(RX_MAX), .RLW(RLW)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_hdr_valid (rx_hdr_valid),
    .rx_hdr_ready (rx_hdr_ready),
    .rx_hdr_len   (rx_hdr_len),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_data      (rx_data),
    .rx_reset     (rx_reset),
    .rx_err       (rx_err),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rx_count     (rx_count)
  );

endmodule

// File: rtl/mfr_checker.sv
module mfr_checker #(
  parameter int RX_MAX = 4224,
  parameter int RLW    = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tx_busy,
  input logic           req_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_data,
  input logic           out_eof,
  input logic           out_eom,
  input logic           out_nil,
  input logic           wr_en,
  input logic           rx_reset,
  input logic [RLW-1:0] rx_count
);

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !req_ready);

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof) && $stable(out_eom)));

  // R5
  eom_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eom) |-> out_eof);

  // R3
  nil_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_nil |-> !out_valid);

  // R8
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(rx_count) < RX_MAX));

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (rx_count == '0));

endmodule

bind mic_fragmenter mfr_checker #(.RX_MAX(RX_MAX), .RLW(RLW)) u_mfr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_busy   (tx_busy),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_eof   (out_eof),
  .out_eom   (out_eom),
  .out_nil   (out_nil),
  .wr_en     (wr_en),
  .rx_reset  (rx_reset),
  .rx_count  (rx_count)
);

// File: tb/mic_fragmenter_test.sv
`timescale 1ns/1ps
module mic_fragmenter_test;

  localparam int RXM = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_start = 1'b0;
  logic [12:0] tx_len = '0;
  logic        tx_busy;
  logic [12:0] buf_addr;
  logic [7:0]  buf_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_max = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_som, out_eof, out_eom, out_nil;
  logic        rx_hdr_valid = 1'b0;
  logic        rx_hdr_ready;
  logic [4:0]  rx_hdr_len = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_reset = 1'b0;
  logic        rx_err;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [4:0]  rx_count;

  logic [7:0] mem [0:63];
  logic [7:0] exp_b [0:79];
  logic [7:0] got_b [0:79];
  int checks = 0;
  int fails = 0;
  int cur_pos, cur_total;
  int som_bad, eof_bad, eom_bad;
  bit finished = 0;

  assign buf_data = mem[buf_addr[5:0]];

  always #5 clk = ~clk;

  mic_fragmenter #(.RX_MAX(RXM)) uut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len), .tx_busy(tx_busy),
    .buf_addr(buf_addr), .buf_data(buf_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_max(req_max), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_som(out_som), .out_eof(out_eof), .out_eom(out_eom), .out_nil(out_nil),
    .rx_hdr_valid(rx_hdr_valid), .rx_hdr_ready(rx_hdr_ready), .rx_hdr_len(rx_hdr_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_reset(rx_reset),
    .rx_err(rx_err), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rx_count(rx_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, mem[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
    end
    return c;
  endfunction

  // load a response and wait out the check pass (R6)
  task automatic load(input int len, input int seed, input bit dbl);
    logic [31:0] c;
    int n;
    for (int i = 0; i < 64; i++) mem[i] = 8'((seed * 37) ^ (i * 11) ^ (i << 4));
    c = ref_crc(len);
    for (int i = 0; i < len; i++) exp_b[i] = mem[i];
    for (int j = 0; j < 4; j++) exp_b[len + j] = c[8*j +: 8];
    @(negedge clk); tx_start = 1'b1; tx_len = 13'(len);
    @(negedge clk); tx_start = 1'b0; #1;
    if (len > 0) chk(tx_busy && !req_ready, "R6 busy after start", int'(tx_busy), 1);
    n = 0;
    while (tx_busy && n < 200) begin
      n++;
      @(negedge clk);
      tx_start = dbl && (n == 2);
      if (dbl && n == 2) tx_len = 13'd2;
      #1;
    end
    tx_start = 1'b0;
    tx_len = 13'(len);
    chk(n == len, "R6 busy cycle count", n, len);
    cur_pos = 0; cur_total = len + 4;
    som_bad = 0; eof_bad = 0; eom_bad = 0;
  endtask

  task automatic pull(input int mx, input bit bp, output int got_n, output bit got_nil);
    int k, g, exp_n;
    bit done;
    exp_n = (mx < cur_total - cur_pos) ? mx : cur_total - cur_pos;
    @(negedge clk); req_valid = 1'b1; req_max = 8'(mx); #1;
    g = 0;
    while (!req_ready && g < 1000) begin @(negedge clk); #1; g++; end
    @(negedge clk); req_valid = 1'b0;
    k = 0; got_nil = 0; done = 0; g = 0;
    while (!done && g < 200) begin
      out_ready = bp ? (g % 3 != 1) : 1'b1;
      #1;
      if (out_nil) begin
        got_nil = 1; done = 1;
      end else if (out_valid && out_ready) begin
        got_b[cur_pos + k] = out_data;
        if (out_som != (cur_pos == 0)) som_bad++;
        if (out_eof != (k == exp_n - 1)) eof_bad++;
        if (out_eom != (cur_pos + k == cur_total - 1)) eom_bad++;
        k++;
        if (out_eof) done = 1;
      end
      if (!done) @(negedge clk);
      g++;
    end
    out_ready = 1'b1;
    cur_pos += k;
    got_n = k;
  endtask

  task automatic run_msg(input int len, input int seed, input int mx0, input bit bp, input bit dbl);
    int gn, f, mx, en, bad_p, bad_c;
    bit gnil;
    load(len, seed, dbl);
    // R3 zero maximum gives an empty result and does not move
    pull(0, 0, gn, gnil);
    chk(gnil && gn == 0, "R3 zero max nil", gn, 0);
    f = 0;
    while (cur_pos < cur_total && f < 100) begin
      mx = mx0 + (f % 2);
      en = (mx < cur_total - cur_pos) ? mx : cur_total - cur_pos;
      pull(mx, bp, gn, gnil);
      chk(gn == en && !gnil, "R3 fragment size", gn, en);
      f++;
    end
    bad_p = 0; bad_c = 0;
    for (int i = 0; i < cur_total; i++)
      if (got_b[i] !== exp_b[i]) begin
        if (i < len) bad_p++; else bad_c++;
      end
    chk(bad_p == 0, "R2 payload bytes", bad_p, 0);
    chk(bad_c == 0, "R1 check bytes", bad_c, 0);
    chk(som_bad == 0 && eof_bad == 0, "R4 som/eof flags", som_bad + eof_bad, 0);
    chk(eom_bad == 0, "R5 eom flag", eom_bad, 0);
    pull(4, 0, gn, gnil);
    chk(gnil && gn == 0, "R5 cleared after eom", gn, 0);
  endtask

  task automatic rx_frag(input int len, input int seed, input bit ok);
    int base, writes, abad, g;
    base = int'(rx_count);
    writes = 0; abad = 0;
    @(negedge clk); rx_hdr_valid = 1'b1; rx_hdr_len = 5'(len); #1;
    g = 0;
    while (!rx_hdr_ready && g < 100) begin @(negedge clk); #1; g++; end
    @(negedge clk); rx_hdr_valid = 1'b0; #1;
    chk(rx_err == !ok, "R8 overflow error pulse", int'(rx_err), int'(!ok));
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = 8'(seed + i); #1;
      g = 0;
      while (!rx_ready && g < 100) begin @(negedge clk); #1; g++; end
      if (wr_en) begin
        if (int'(wr_addr) != base + writes || wr_data != 8'(seed + i)) abad++;
        writes++;
      end
      @(negedge clk);
    end
    rx_valid = 1'b0; #1;
    chk(writes == (ok ? len : 0) && abad == 0, "R8 bytes written", writes, ok ? len : 0);
    chk(int'(rx_count) == base + (ok ? len : 0), "R8 stored length", int'(rx_count), base + (ok ? len : 0));
  endtask

  task automatic rx_clear();
    @(negedge clk); rx_reset = 1'b1;
    @(negedge clk); rx_reset = 1'b0; #1;
    chk(rx_count == 0 && rx_hdr_ready, "R9 clear", int'(rx_count), 0);
  endtask

  initial begin
    int lens [6];
    lens = '{1, 2, 3, 4, 7, 200};
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && rx_hdr_ready && !out_valid && !tx_busy && rx_count == 0,
        "R10 reset state", int'(out_valid), 0);
    rst_n = 1'b1;

    // sweep lengths and fragment sizes
    for (int len = 0; len <= 12; len++)
      for (int m = 0; m < 6; m++)
        run_msg(len, len * 6 + m, lens[m], (len + m) % 2 == 1, 1'b0);

    // second start during the check pass must be ignored (R6)
    run_msg(6, 99, 3, 1'b0, 1'b1);

    // receive side
    rx_frag(8, 10, 1'b1);
    rx_frag(12, 40, 1'b1);
    rx_frag(1, 70, 1'b0);
    rx_frag(0, 0, 1'b1);
    rx_clear();
    rx_frag(21, 5, 1'b0);
    rx_frag(20, 3, 1'b1);
    rx_clear();
    // clear in the middle of a fragment (R9)
    @(negedge clk); rx_hdr_valid = 1'b1; rx_hdr_len = 5'd5;
    @(negedge clk); rx_hdr_valid = 1'b0; rx_valid = 1'b1; rx_data = 8'h11;
    @(negedge clk); rx_data = 8'h22;
    @(negedge clk); rx_valid = 1'b0;
    rx_clear();
    rx_frag(4, 8, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule